// File: doc/BRIEF.md
# Message Signaled Interrupt Capability and Message Composer

This block implements the interrupt capability structure of one PCI Express endpoint function. It holds four configuration words: a header/control word, a lower and an optional upper message address, and a message data word. Software reaches them through a plain 32-bit configuration port that is addressed by byte offset. Writes take effect on the clock edge. Reads are combinational from the current offset.

Once software has set the enable bit, function logic may raise an interrupt by presenting a vector number together with a one-cycle strobe. The block checks the vector against the number of vectors software has granted. It then latches a 64-bit target address and a 32-bit payload, with the low payload bits replaced by the vector number. The pair is presented on a valid/ready request port until the consumer accepts it. A single 64-bit addressing enable decides the layout of the third and fourth words: with it set, they hold the upper address and the data; with it clear, the third word holds the data.

Top module: `msi_cap`

## Requirements
- R1: The control word at offset 0x050 reads back as follows: bits [7:0] = 0x05; bits [15:8] = the NEXT_PTR parameter (default 0x68); bit 16 = enable; bits [22:20] = vector-grant exponent k (2^k vectors); bit 23 = 64-bit addressing enable. All other bits read 0, and every writable field resets to 0.
- R2: A write of k greater than VEC_LOG2_MAX (default 5) to bits [22:20] stores VEC_LOG2_MAX.
- R3: The lower address word at offset 0x054 stores bits [31:2] as written, and bits [1:0] always read 0.
- R4: With bit 23 set, offset 0x058 is the read/write upper address word. With bit 23 clear, the upper word is not visible at any offset and does not take part in the target address.
- R5: The data word sits at offset 0x058 when bit 23 is clear and at 0x05C when it is set. Bits [15:0] are read/write, and bits [31:16] read 0.
- R6: Any offset that is not mapped in the current mode reads 0. This includes 0x05C while bit 23 is clear.
- R7: While the enable bit is 0, no strobe produces a request.
- R8: The request payload is the data word, with its low k bits replaced by the vector number and bits [31:16] equal to 0.
- R9: A strobe whose vector number is 2^k or higher produces no request.
- R10: The request address is {upper, lower} when bit 23 is set and the lower word zero-extended when it is clear. Bits [1:0] are always 0.
- R11: Once raised, req_valid stays high with a stable address and payload until the clock edge where req_ready is high, and it falls on the next cycle.
- R11: A strobe that arrives while a request is pending, including the cycle of its completion, is dropped.
- R12: Writes to the read-only capability ID and next-pointer fields, and to reserved bits, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 12 | Configuration byte offset |
| cfg_wen | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr |
| irq_stb | input | 1 | One-cycle interrupt raise strobe |
| irq_vec | input | 5 | Interrupt vector number |
| req_valid | output | 1 | Message request pending |
| req_ready | input | 1 | Consumer accepts the request |
| req_addr | output | 64 | Message target address |
| req_data | output | 32 | Message payload |

## Verification
The hardest situation to bring about is a strobe that lands while a request is stalled. Getting there needs an enabled function, a granted vector and a consumer that is holding ready low. The bench drives ready low by hand and fires a first vector. It then fires a second vector during the stall. The monitor checks every stalled cycle for a held address and payload, and the scoreboard expects exactly one message. The same data word is also read at both of its possible offsets, before and after the addressing mode is toggled. This shows that the upper address stays stored while it is hidden.

// File: rtl/msi_pkg.sv
package msi_pkg;

    localparam logic [7:0] CAP_ID_MSI   = 8'h05;
    localparam int         CTRL_EN_BIT  = 16;
    localparam int         CTRL_K_LSB   = 20;
    localparam int         CTRL_A64_BIT = 23;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_ADDR_LO,
        SEL_ADDR_HI,
        SEL_DATA
    } reg_sel_e;

    typedef struct packed {
        logic        en;
        logic [2:0]  k;
        logic        a64;
        logic [29:0] lo;
        logic [31:0] hi;
        logic [15:0] data;
    } cap_regs_t;

    typedef struct packed {
        logic        busy;
        logic [63:0] addr;
        logic [31:0] data;
    } req_state_t;

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
    import msi_pkg::*;
#(
    parameter int         CFG_AW       = 12,
    parameter int         CAP_BASE     = 'h050,
    parameter logic [7:0] NEXT_PTR     = 8'h68,
    parameter bit         ADDR64_CAP   = 1'b1,
    parameter int         VEC_LOG2_MAX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_wen,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              msi_en,
    output logic [2:0]        vec_k,
    output logic              a64_on,
    output logic [31:0]       addr_lo,
    output logic [31:0]       addr_hi,
    output logic [15:0]       msg_data
);

    localparam logic [CFG_AW-1:0] OFF_CTRL = CFG_AW'(CAP_BASE);
    localparam logic [CFG_AW-1:0] OFF_LO   = CFG_AW'(CAP_BASE + 4);
    localparam logic [CFG_AW-1:0] OFF_W2   = CFG_AW'(CAP_BASE + 8);
    localparam logic [CFG_AW-1:0] OFF_W3   = CFG_AW'(CAP_BASE + 12);
    localparam logic [2:0]        K_MAX    = 3'(VEC_LOG2_MAX);
    localparam logic              A64_W    = ADDR64_CAP;

    cap_regs_t  regs_d, regs_q;
    reg_sel_e   sel;
    logic [2:0] k_req;

    // Offset decode; the third and fourth words move with the addressing mode
    always_comb begin
        sel = SEL_NONE;
        if (cfg_addr == OFF_CTRL) begin
            sel = SEL_CTRL;
        end else if (cfg_addr == OFF_LO) begin
            sel = SEL_ADDR_LO;
        end else if (cfg_addr == OFF_W2) begin
            sel = regs_q.a64 ? SEL_ADDR_HI : SEL_DATA;
        end else if ((cfg_addr == OFF_W3) && regs_q.a64) begin
            sel = SEL_DATA;
        end
    end

    // Next-state computation
    always_comb begin
        regs_d = regs_q;
        k_req  = cfg_wdata[CTRL_K_LSB +: 3];
        if (cfg_wen) begin
            unique case (sel)
                SEL_CTRL: begin
                    regs_d.en  = cfg_wdata[CTRL_EN_BIT];
                    regs_d.k   = (k_req > K_MAX) ? K_MAX : k_req;
                    regs_d.a64 = A64_W & cfg_wdata[CTRL_A64_BIT];
                end
                SEL_ADDR_LO: regs_d.lo   = cfg_wdata[31:2];
                SEL_ADDR_HI: regs_d.hi   = cfg_wdata;
                SEL_DATA:    regs_d.data = cfg_wdata[15:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Read-back mux
    always_comb begin
        unique case (sel)
            SEL_CTRL:    cfg_rdata = {8'h00, regs_q.a64, regs_q.k, 3'b000,
                                      regs_q.en, NEXT_PTR, CAP_ID_MSI};
            SEL_ADDR_LO: cfg_rdata = {regs_q.lo, 2'b00};
            SEL_ADDR_HI: cfg_rdata = regs_q.hi;
            SEL_DATA:    cfg_rdata = {16'h0000, regs_q.data};
            default:     cfg_rdata = '0;
        endcase
    end

    assign msi_en   = regs_q.en;
    assign vec_k    = regs_q.k;
    assign a64_on   = regs_q.a64;
    assign addr_lo  = {regs_q.lo, 2'b00};
    assign addr_hi  = regs_q.hi;
    assign msg_data = regs_q.data;

    // R2: stored grant exponent never exceeds the configured ceiling
    a_r2_k_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        vec_k <= K_MAX);

    // R3: the lower address always reads Dword aligned
    a_r3_lo_dword: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == OFF_LO) |-> (cfg_rdata[1:0] == 2'b00));

    // R4: with 64-bit mode off, the third word shows only the 16-bit data
    a_r4_hi_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (!a64_on && (cfg_addr == OFF_W2)) |-> (cfg_rdata[31:16] == 16'h0000));

    // R12: identity fields are constant whatever is written
    a_r12_ro_ident: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == OFF_CTRL) |-> (cfg_rdata[15:0] == {NEXT_PTR, CAP_ID_MSI}));

endmodule

// File: rtl/msi_msg_encode.sv
module msi_msg_encode #(
    parameter int VEC_W = 5
) (
    input  logic [2:0]       vec_k,
    input  logic [VEC_W-1:0] vec,
    input  logic [15:0]      msg_data,
    input  logic             a64_on,
    input  logic [31:0]      addr_lo,
    input  logic [31:0]      addr_hi,
    output logic             vec_ok,
    output logic [31:0]      payload,
    output logic [63:0]      target
);

    localparam int DATA_W = 16;

    logic [DATA_W-1:0] vec_mask;
    logic [DATA_W-1:0] vec_ext;

    // One mask bit per payload bit that the vector may occupy
    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
        if (b < VEC_W) begin : g_live
            assign vec_mask[b] = ({29'd0, vec_k} > 32'(b));
        end else begin : g_dead
            assign vec_mask[b] = 1'b0;
        end
    end

    assign vec_ext = DATA_W'(vec);
    assign vec_ok  = ((32'(vec) >> vec_k) == 32'd0);
    assign payload = {16'h0000, (msg_data & ~vec_mask) | (vec_ext & vec_mask)};
    assign target  = a64_on ? {addr_hi, addr_lo} : {32'h0000_0000, addr_lo};

endmodule

// File: rtl/msi_req_ctrl.sv
module msi_req_ctrl
    import msi_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        irq_stb,
    input  logic        vec_ok,
    input  logic        msi_en,
    input  logic [31:0] payload,
    input  logic [63:0] target,
    input  logic        req_ready,
    output logic        req_valid,
    output logic [63:0] req_addr,
    output logic [31:0] req_data
);

    req_state_t st_d, st_q;
    logic       take;

    always_comb begin
        st_d = st_q;
        take = irq_stb && msi_en && vec_ok && !st_q.busy;
        if (st_q.busy && req_ready) begin
            st_d.busy = 1'b0;
        end
        if (take) begin
            st_d.busy = 1'b1;
            st_d.addr = target;
            st_d.data = payload;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_valid = st_q.busy;
    assign req_addr  = st_q.addr;
    assign req_data  = st_q.data;

    // R11: pending request holds its contents until accepted
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_data)));

    // R11: an accepted request is withdrawn on the next cycle
    a_r11_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid);

    // R7: a request only starts from an enabled strobe
    a_r7_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> ($past(msi_en) && $past(irq_stb)));

    // R9: a request only starts for a granted vector
    a_r9_granted_vec: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(vec_ok));

    // R10: target address is Dword aligned
    a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[1:0] == 2'b00));

endmodule

// File: rtl/msi_cap.sv
module msi_cap #(
    parameter int         CFG_AW       = 12,
    parameter int         CAP_BASE     = 'h050,
    parameter logic [7:0] NEXT_PTR     = 8'h68,
    parameter bit         ADDR64_CAP   = 1'b1,
    parameter int         VEC_LOG2_MAX = 5,
    localparam int        VEC_W        = (VEC_LOG2_MAX < 1) ? 1 : VEC_LOG2_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_wen,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              irq_stb,
    input  logic [VEC_W-1:0]  irq_vec,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [63:0]       req_addr,
    output logic [31:0]       req_data
);

    logic        msi_en;
    logic [2:0]  vec_k;
    logic        a64_on;
    logic [31:0] addr_lo;
    logic [31:0] addr_hi;
    logic [15:0] msg_data;
    logic        vec_ok;
    logic [31:0] payload;
    logic [63:0] target;

    msi_cfg_regs #(
        .CFG_AW      (CFG_AW),
        .CAP_BASE    (CAP_BASE),
        .NEXT_PTR    (NEXT_PTR),
        .ADDR64_CAP  (ADDR64_CAP),
        .VEC_LOG2_MAX(VEC_LOG2_MAX)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_addr (cfg_addr),
        .cfg_wen  (cfg_wen),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .msi_en   (msi_en),
        .vec_k    (vec_k),
        .a64_on   (a64_on),
        .addr_lo  (addr_lo),
        .addr_hi  (addr_hi),
        .msg_data (msg_data)
    );

    msi_msg_encode #(
        .VEC_W(VEC_W)
    ) u_enc (
        .vec_k   (vec_k),
        .vec     (irq_vec),
        .msg_data(msg_data),
        .a64_on  (a64_on),
        .addr_lo (addr_lo),
        .addr_hi (addr_hi),
        .vec_ok  (vec_ok),
        .payload (payload),
        .target  (target)
    );

    msi_req_ctrl u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_stb  (irq_stb),
        .vec_ok   (vec_ok),
        .msi_en   (msi_en),
        .payload  (payload),
        .target   (target),
        .req_ready(req_ready),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .req_data (req_data)
    );

endmodule

// File: tb/sim_msi_cap.sv
module sim_msi_cap;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic        cfg_wen = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq_stb = 1'b0;
    logic [4:0]  irq_vec = '0;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [63:0] req_addr;
    logic [31:0] req_data;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic [63:0] a;
        logic [31:0] d;
    } item_t;
    item_t sb[$];

    // shadow of what software programmed
    logic [31:0] s_lo = '0;
    logic [31:0] s_hi = '0;
    logic [15:0] s_data = '0;
    int          s_k = 0;
    bit          s_a64 = 0;

    bit          rdy_auto = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    msi_cap u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr(cfg_addr), .cfg_wen(cfg_wen), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .irq_stb(irq_stb), .irq_vec(irq_vec),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data)
    );

    always @(posedge clk) begin
        #2;
        if (rdy_auto) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            req_ready = lfsr[0] | lfsr[3];
        end
    end

    // monitor: scoreboard pop and hold check
    bit          stall_prev = 0;
    logic [63:0] hold_a;
    logic [31:0] hold_d;
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_prev) begin
                tests++;
                if (!req_valid || req_addr !== hold_a || req_data !== hold_d) begin
                    fails++;
                    $display("FAIL R11 hold: valid=%0b addr=%h data=%h expected valid=1 addr=%h data=%h",
                             req_valid, req_addr, req_data, hold_a, hold_d);
                end
            end
            if (req_valid && req_ready) begin
                tests++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL R7/R9/R11 unexpected request addr=%h data=%h expected none",
                             req_addr, req_data);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    if (req_addr !== it.a || req_data !== it.d) begin
                        fails++;
                        $display("FAIL R8/R10 message addr=%h data=%h expected addr=%h data=%h",
                                 req_addr, req_data, it.a, it.d);
                    end
                end
            end
            stall_prev = req_valid && !req_ready;
            hold_a = req_addr;
            hold_d = req_data;
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        cfg_addr = a; cfg_wdata = d; cfg_wen = 1'b1;
        @(posedge clk); #2;
        cfg_wen = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #2;
        cfg_addr = a;
        @(negedge clk);
        tests++;
        if (cfg_rdata !== exp) begin
            fails++;
            $display("FAIL %s read 0x%h: got %h expected %h", tag, a, cfg_rdata, exp);
        end
    endtask

    function automatic item_t expect_msg(input int v);
        item_t it;
        logic [15:0] m;
        m = 16'((32'd1 << s_k) - 1);
        it.d = {16'h0, (s_data & ~m) | (16'(v) & m)};
        it.a = s_a64 ? {s_hi, s_lo} : {32'h0, s_lo};
        return it;
    endfunction

    task automatic strobe(input int v, input bit exp_msg);
        @(posedge clk); #2;
        irq_stb = 1'b1; irq_vec = 5'(v);
        if (exp_msg) sb.push_back(expect_msg(v));
        @(posedge clk); #2;
        irq_stb = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (sb.size() == 0) break;
        end
        @(posedge clk); #2;
    endtask

    task automatic idle_chk(input string tag);
        repeat (4) @(negedge clk);
        tests++;
        if (req_valid !== 1'b0) begin
            fails++;
            $display("FAIL %s: req_valid=%0b expected 0", tag, req_valid);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // reset state (R1, R6)
        rd_chk(12'h050, 32'h0000_6805, "R1 reset ctrl");
        rd_chk(12'h054, 32'h0, "R3 reset lo");
        rd_chk(12'h058, 32'h0, "R5 reset data");
        rd_chk(12'h05C, 32'h0, "R6 unmapped in 32-bit mode");
        rd_chk(12'h060, 32'h0, "R6 unmapped");
        tests++;
        if (req_valid !== 1'b0) begin
            fails++;
            $display("FAIL R11 reset valid: got %0b expected 0", req_valid);
        end

        // R12, R2: all-ones write to control
        wr(12'h050, 32'hFFFF_FFFF);
        rd_chk(12'h050, 32'h00D1_6805, "R12 R2 ctrl all ones");
        wr(12'h050, 32'h0);
        rd_chk(12'h050, 32'h0000_6805, "R1 ctrl cleared");

        // R3 lower address alignment
        wr(12'h054, 32'hFFFF_FFFF);
        rd_chk(12'h054, 32'hFFFF_FFFC, "R3 lo ones");
        wr(12'h054, 32'hFEE0_1003);
        s_lo = 32'hFEE0_1000;
        rd_chk(12'h054, 32'hFEE0_1000, "R3 lo value");

        // R5 data in 32-bit mode
        wr(12'h058, 32'hABCD_1234);
        s_data = 16'h1234;
        rd_chk(12'h058, 32'h0000_1234, "R5 data at 0x058");

        // R4 switch to 64-bit mode
        wr(12'h050, 32'h0080_0000);
        rd_chk(12'h058, 32'h0, "R4 hi reset");
        rd_chk(12'h05C, 32'h0000_1234, "R5 data moved to 0x05C");
        wr(12'h058, 32'h1234_5678);
        s_hi = 32'h1234_5678;
        rd_chk(12'h058, 32'h1234_5678, "R4 hi value");
        wr(12'h050, 32'h0);
        rd_chk(12'h058, 32'h0000_1234, "R4 hi hidden when off");
        rd_chk(12'h05C, 32'h0, "R6 0x05C unmapped again");

        // R7 no message while disabled
        strobe(0, 0);
        idle_chk("R7 disabled strobe");

        // R8 R10: one vector, 32-bit address
        wr(12'h050, 32'h0001_0000);
        s_k = 0; s_a64 = 0;
        strobe(0, 1); drain();
        // R9 out of range for one vector
        strobe(1, 0);
        idle_chk("R9 vec 1 with 1 granted");

        // four vectors
        wr(12'h050, 32'h0021_0000);
        s_k = 2;
        strobe(3, 1); drain();
        strobe(2, 1); drain();
        strobe(4, 0);
        idle_chk("R9 vec 4 with 4 granted");

        // 32 vectors, 64-bit address
        wr(12'h050, 32'h00D1_0000);
        s_k = 5; s_a64 = 1;
        strobe(31, 1); drain();
        strobe(0, 1); drain();

        // R11 strobe during a stall is dropped
        req_ready = 1'b0;
        strobe(5, 1);
        strobe(6, 0);
        repeat (4) @(posedge clk);
        #2 req_ready = 1'b1;
        drain();
        idle_chk("R11 stalled strobe dropped");

        // R11 handshake under irregular ready
        rdy_auto = 1;
        for (int i = 0; i < 12; i++) begin
            strobe((i * 7) % 32, 1);
            drain();
        end
        rdy_auto = 0;
        @(posedge clk); #2 req_ready = 1'b1;

        // R7 disable again
        wr(12'h050, 32'h00D0_0000);
        strobe(3, 0);
        idle_chk("R7 re-disabled strobe");

        tests++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R8 missing messages: got %0d left expected 0", sb.size());
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule